// File: doc/BRIEF.md
# Table-Driven Two-Image Pixel Combiner

This block is a memory-to-memory engine. It walks two source images stored as 12-bit pixels, with 4 bits each for red, green and blue. It combines them pixel by pixel through a small programmable table and writes the results to a destination region. The work is done in chunks of up to one burst. For each chunk the engine fetches a burst from the first image into its own FIFO, then a burst from the second image into a second FIFO. It then drains both FIFOs in lockstep through the table into an output FIFO. Finally it writes that FIFO back as one burst, and all three pointers step forward by the chunk length.

The pixel operation is defined entirely by the table contents. Loading different tables makes the same hardware blend two images, sort pixels into three threshold classes, clear a region to black, or copy either input. The host loads the table while the engine is idle, programs the base addresses and the pixel count, and pulses start. Busy stays high for the whole job, and done pulses for one cycle at the end.

Top module: `pcomb_top`

## Requirements
- R1: Each output channel equals table[{a_ch, b_ch}], with the first image's 4-bit channel in address bits [7:4] and the second image's channel in bits [3:0]. Red is pixel bits [11:8], green [7:4] and blue [3:0], and all three channels share one 256-entry table of 4-bit values.
- R2: Each chunk issues a read request for the first image, then one for the second image, then a write request. Read and write requests are never active together. The requested addresses start at the programmed bases and advance by the chunk length after each chunk.
- R3: The request length is the smaller of BURST and the pixels still outstanding, so a count that is not a multiple of BURST ends with a short chunk. No location past base+count in the destination is written.
- R4: A read or write request, with its address and length, stays asserted and unchanged until it is acknowledged.
- R5: While write data is offered and not accepted, the offered data stays unchanged. Read data is accepted only in the read phase of the matching image.
- R6: A start pulse while idle with a nonzero count raises busy in the next cycle. A start pulse while busy has no effect on the running job.
- R7: Done is high for exactly one cycle after the last write beat of a job, and busy is low in that cycle.
- R8: A start with a count of zero gives a done pulse in the next cycle and issues no memory request.
- R9: Table writes presented while busy are ignored.
- R10: After reset, busy, done, both request outputs, read-ready and write-valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for a job |
| cfg_src_a | input | ADDR_W | Base address of the first image (pixel units) |
| cfg_src_b | input | ADDR_W | Base address of the second image |
| cfg_dst | input | ADDR_W | Base address of the destination |
| cfg_count | input | CNT_W | Number of pixels to process |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 8 | Table entry index |
| tbl_data | input | 4 | Table entry value |
| mem_rd_req | output | 1 | Read burst request |
| mem_rd_addr | output | ADDR_W | Read burst start address |
| mem_rd_len | output | LEN_W | Read burst length in beats |
| mem_rd_ack | input | 1 | Read request accepted |
| mem_rd_valid | input | 1 | Read data beat valid |
| mem_rd_data | input | 12 | Read data pixel |
| mem_rd_ready | output | 1 | Engine accepts a read beat |
| mem_wr_req | output | 1 | Write burst request |
| mem_wr_addr | output | ADDR_W | Write burst start address |
| mem_wr_len | output | LEN_W | Write burst length in beats |
| mem_wr_ack | input | 1 | Write request accepted |
| mem_wr_valid | output | 1 | Write data beat valid |
| mem_wr_data | output | 12 | Write data pixel |
| mem_wr_ready | input | 1 | Memory accepts a write beat |

## Verification
The hardest case to reach is a full check of the table indexing on every channel. Every one of the 256 (first, second) nibble pairs must pass through red, green and blue, while the memory side stalls requests and beats. The bench fills both images so that pixel i carries a distinct bijection of the pair (i/16, i%16) on each channel. One 256-pixel job therefore covers all pairs on all channels, and the request and data handshakes are held off with repeating gap patterns. A second job starts at unaligned bases with a count of 150 to reach the short final chunk. Table writes and a stray start are issued in the middle of a running job.

// File: rtl/pcomb_pkg.sv
package pcomb_pkg;
  localparam int unsigned CH_W   = 4;
  localparam int unsigned N_CH   = 3;
  localparam int unsigned PIX_W  = CH_W * N_CH;
  localparam int unsigned TBL_AW = 2 * CH_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDA_REQ,
    ST_RDA_DAT,
    ST_RDB_REQ,
    ST_RDB_DAT,
    ST_PROC,
    ST_WR_REQ,
    ST_WR_DAT
  } pc_state_e;
endpackage

// File: rtl/pcomb_fifo.sv
module pcomb_fifo #(
  parameter int unsigned W     = 12,
  parameter int unsigned DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [W-1:0] store [DEPTH];
  logic [PW:0]  wr_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_q[PW-1:0]] <= din;
  end

  assign dout  = store[rd_q[PW-1:0]];
  assign empty = (wr_q == rd_q);
  assign full  = (wr_q[PW] != rd_q[PW]) && (wr_q[PW-1:0] == rd_q[PW-1:0]);
endmodule

// File: rtl/pcomb_lut.sv
module pcomb_lut
  import pcomb_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [TBL_AW-1:0] waddr,
  input  logic [CH_W-1:0]   wdata,
  input  logic [PIX_W-1:0]  a_px,
  input  logic [PIX_W-1:0]  b_px,
  output logic [PIX_W-1:0]  y_px
);
  localparam int unsigned ENTRIES = 1 << TBL_AW;

  logic [CH_W-1:0] tbl [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) tbl[waddr] <= wdata;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign y_px[c*CH_W +: CH_W] = tbl[{a_px[c*CH_W +: CH_W], b_px[c*CH_W +: CH_W]}];
  end
endmodule

// File: rtl/pcomb_ctrl.sv
module pcomb_ctrl
  import pcomb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BURST  = 64,
  localparam int unsigned LEN_W = $clog2(BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_src_a,
  input  logic [ADDR_W-1:0] cfg_src_b,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic              busy,
  output logic              done,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  input  logic              rd_ack,
  input  logic              rd_valid,
  output logic              rd_ready,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_W-1:0]  wr_len,
  input  logic              wr_ack,
  output logic              wr_valid,
  input  logic              wr_ready,
  input  logic              fa_full,
  input  logic              fb_full,
  input  logic              fa_empty,
  input  logic              fb_empty,
  input  logic              fo_full,
  input  logic              fo_empty,
  output logic              push_a,
  output logic              push_b,
  output logic              fire,
  output logic              pop_o
);
  pc_state_e         state_q, state_d;
  logic [ADDR_W-1:0] ptr_a_q, ptr_a_d, ptr_b_q, ptr_b_d, ptr_d_q, ptr_d_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic [LEN_W-1:0]  beat_q, beat_d;
  logic              done_q, done_d;
  logic [LEN_W-1:0]  chunk;
  logic              last_beat;

  assign chunk     = (remain_q > CNT_W'(BURST)) ? LEN_W'(BURST) : remain_q[LEN_W-1:0];
  assign last_beat = (beat_q == chunk - 1'b1);

  always_comb begin
    state_d  = state_q;
    ptr_a_d  = ptr_a_q;
    ptr_b_d  = ptr_b_q;
    ptr_d_d  = ptr_d_q;
    remain_d = remain_q;
    beat_d   = beat_q;
    done_d   = 1'b0;
    rd_req   = 1'b0;
    rd_ready = 1'b0;
    wr_req   = 1'b0;
    wr_valid = 1'b0;
    push_a   = 1'b0;
    push_b   = 1'b0;
    fire     = 1'b0;
    pop_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (cfg_count == '0) begin
            done_d = 1'b1;
          end else begin
            ptr_a_d  = cfg_src_a;
            ptr_b_d  = cfg_src_b;
            ptr_d_d  = cfg_dst;
            remain_d = cfg_count;
            state_d  = ST_RDA_REQ;
          end
        end
      end
      ST_RDA_REQ: begin
        rd_req = 1'b1;
        if (rd_ack) begin
          beat_d  = '0;
          state_d = ST_RDA_DAT;
        end
      end
      ST_RDA_DAT: begin
        rd_ready = !fa_full;
        push_a   = rd_valid && !fa_full;
        if (push_a) begin
          beat_d = beat_q + 1'b1;
          if (last_beat) state_d = ST_RDB_REQ;
        end
      end
      ST_RDB_REQ: begin
        rd_req = 1'b1;
        if (rd_ack) begin
          beat_d  = '0;
          state_d = ST_RDB_DAT;
        end
      end
      ST_RDB_DAT: begin
        rd_ready = !fb_full;
        push_b   = rd_valid && !fb_full;
        if (push_b) begin
          beat_d = beat_q + 1'b1;
          if (last_beat) begin
            beat_d  = '0;
            state_d = ST_PROC;
          end
        end
      end
      ST_PROC: begin
        fire = !fa_empty && !fb_empty && !fo_full;
        if (fire) begin
          beat_d = beat_q + 1'b1;
          if (last_beat) state_d = ST_WR_REQ;
        end
      end
      ST_WR_REQ: begin
        wr_req = 1'b1;
        if (wr_ack) begin
          beat_d  = '0;
          state_d = ST_WR_DAT;
        end
      end
      ST_WR_DAT: begin
        wr_valid = !fo_empty;
        pop_o    = wr_valid && wr_ready;
        if (pop_o) begin
          beat_d = beat_q + 1'b1;
          if (last_beat) begin
            ptr_a_d  = ptr_a_q + ADDR_W'(chunk);
            ptr_b_d  = ptr_b_q + ADDR_W'(chunk);
            ptr_d_d  = ptr_d_q + ADDR_W'(chunk);
            remain_d = remain_q - CNT_W'(chunk);
            if (remain_q == CNT_W'(chunk)) begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              state_d = ST_RDA_REQ;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ptr_a_q  <= '0;
      ptr_b_q  <= '0;
      ptr_d_q  <= '0;
      remain_q <= '0;
      beat_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      ptr_a_q  <= ptr_a_d;
      ptr_b_q  <= ptr_b_d;
      ptr_d_q  <= ptr_d_d;
      remain_q <= remain_d;
      beat_q   <= beat_d;
      done_q   <= done_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign rd_addr = (state_q == ST_RDB_REQ) ? ptr_b_q : ptr_a_q;
  assign rd_len  = chunk;
  assign wr_addr = ptr_d_q;
  assign wr_len  = chunk;
endmodule

// File: rtl/pcomb_top.sv
module pcomb_top
  import pcomb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BURST  = 64,
  localparam int unsigned LEN_W = $clog2(BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_src_a,
  input  logic [ADDR_W-1:0] cfg_src_b,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic              busy,
  output logic              done,
  input  logic              tbl_we,
  input  logic [7:0]        tbl_addr,
  input  logic [3:0]        tbl_data,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic [LEN_W-1:0]  mem_rd_len,
  input  logic              mem_rd_ack,
  input  logic              mem_rd_valid,
  input  logic [11:0]       mem_rd_data,
  output logic              mem_rd_ready,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [LEN_W-1:0]  mem_wr_len,
  input  logic              mem_wr_ack,
  output logic              mem_wr_valid,
  output logic [11:0]       mem_wr_data,
  input  logic              mem_wr_ready
);
  logic             fa_full, fb_full, fa_empty, fb_empty, fo_full, fo_empty;
  logic             push_a, push_b, fire, pop_o;
  logic [PIX_W-1:0] a_head, b_head, y_px;

  pcomb_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST(BURST)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_a(cfg_src_a), .cfg_src_b(cfg_src_b), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
    .busy(busy), .done(done),
    .rd_req(mem_rd_req), .rd_addr(mem_rd_addr), .rd_len(mem_rd_len), .rd_ack(mem_rd_ack),
    .rd_valid(mem_rd_valid), .rd_ready(mem_rd_ready),
    .wr_req(mem_wr_req), .wr_addr(mem_wr_addr), .wr_len(mem_wr_len), .wr_ack(mem_wr_ack),
    .wr_valid(mem_wr_valid), .wr_ready(mem_wr_ready),
    .fa_full(fa_full), .fb_full(fb_full), .fa_empty(fa_empty), .fb_empty(fb_empty),
    .fo_full(fo_full), .fo_empty(fo_empty),
    .push_a(push_a), .push_b(push_b), .fire(fire), .pop_o(pop_o)
  );

  pcomb_fifo #(.W(PIX_W), .DEPTH(BURST)) fifo_a_i (
    .clk(clk), .rst_n(rst_n), .push(push_a), .din(mem_rd_data), .pop(fire),
    .dout(a_head), .empty(fa_empty), .full(fa_full)
  );

  pcomb_fifo #(.W(PIX_W), .DEPTH(BURST)) fifo_b_i (
    .clk(clk), .rst_n(rst_n), .push(push_b), .din(mem_rd_data), .pop(fire),
    .dout(b_head), .empty(fb_empty), .full(fb_full)
  );

  pcomb_lut lut_i (
    .clk(clk), .we(tbl_we && !busy), .waddr(tbl_addr), .wdata(tbl_data),
    .a_px(a_head), .b_px(b_head), .y_px(y_px)
  );

  pcomb_fifo #(.W(PIX_W), .DEPTH(BURST)) fifo_o_i (
    .clk(clk), .rst_n(rst_n), .push(fire), .din(y_px), .pop(pop_o),
    .dout(mem_wr_data), .empty(fo_empty), .full(fo_full)
  );
endmodule

// File: rtl/pcomb_chk.sv
module pcomb_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BURST  = 64,
  localparam int unsigned LEN_W = $clog2(BURST + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  cfg_count,
  input logic              busy,
  input logic              done,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic [LEN_W-1:0]  mem_rd_len,
  input logic              mem_rd_ack,
  input logic              mem_rd_ready,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [LEN_W-1:0]  mem_wr_len,
  input logic              mem_wr_ack,
  input logic              mem_wr_valid,
  input logic [11:0]       mem_wr_data,
  input logic              mem_wr_ready
);
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !((mem_rd_req || mem_rd_ready) && (mem_wr_req || mem_wr_valid)));

  a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || mem_wr_req) |-> (mem_rd_len != '0 && mem_rd_len <= LEN_W'(BURST)));

  a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr) && $stable(mem_rd_len)));

  a_r4_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_len)));

  a_r5_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_data)));

  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cfg_count != '0) |=> busy);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cfg_count == '0) |=> (done && !busy && !mem_rd_req));
endmodule

bind pcomb_top pcomb_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST(BURST)) chk_i (.*);

// File: tb/pcomb_top_tb_top.sv
module pcomb_top_tb_top;
  localparam int BURST = 64;
  localparam int MEMSZ = 1024;

  logic        clk, rst_n, start, busy, done, tbl_we;
  logic [15:0] cfg_src_a, cfg_src_b, cfg_dst, cfg_count;
  logic [7:0]  tbl_addr;
  logic [3:0]  tbl_data;
  logic        mem_rd_req, mem_rd_ack, mem_rd_valid, mem_rd_ready;
  logic [15:0] mem_rd_addr, mem_wr_addr;
  logic [6:0]  mem_rd_len, mem_wr_len;
  logic [11:0] mem_rd_data, mem_wr_data;
  logic        mem_wr_req, mem_wr_ack, mem_wr_valid, mem_wr_ready;

  logic [11:0] mem [MEMSZ];
  logic [3:0]  ref_tbl [256];

  int total = 0, bad = 0;
  int cur_a, cur_b, cur_d, cur_n;
  int rd_bursts, wr_bursts, rd_err, wr_err, hold_err;
  int ra, rl, rk, rgap, wa, wl, wk, wgap, jb, remx, elen;
  logic        prev_stall;
  logic [11:0] prev_data;

  pcomb_top dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // read responder: checks request order, addresses and lengths (R2, R3) and hold (R4)
  initial begin
    mem_rd_ack = 0; mem_rd_valid = 0; mem_rd_data = '0; rgap = 0;
    forever begin
      @(negedge clk);
      if (mem_rd_req) begin
        ra = int'(mem_rd_addr); rl = int'(mem_rd_len);
        jb = rd_bursts / 2;
        remx = cur_n - BURST * jb;
        elen = (remx > BURST) ? BURST : remx;
        if (ra != (((rd_bursts % 2) != 0 ? cur_b : cur_a) + BURST * jb) || rl != elen) rd_err++;
        rd_bursts++;
        repeat (2) begin
          @(negedge clk);
          if (!mem_rd_req || int'(mem_rd_addr) != ra || int'(mem_rd_len) != rl) hold_err++;
        end
        mem_rd_ack = 1; @(negedge clk); mem_rd_ack = 0;
        rk = 0;
        while (rk < rl) begin
          mem_rd_valid = (rgap % 4) != 3; rgap++;
          mem_rd_data = mem[(ra + rk) % MEMSZ];
          if (mem_rd_valid && mem_rd_ready) rk++;
          @(negedge clk);
        end
        mem_rd_valid = 0;
      end
    end
  end

  // write responder: stores data, checks hold under backpressure (R5)
  initial begin
    mem_wr_ack = 0; mem_wr_ready = 0; wgap = 0;
    forever begin
      @(negedge clk);
      if (mem_wr_req) begin
        wa = int'(mem_wr_addr); wl = int'(mem_wr_len);
        remx = cur_n - BURST * wr_bursts;
        elen = (remx > BURST) ? BURST : remx;
        if (wa != cur_d + BURST * wr_bursts || wl != elen) wr_err++;
        wr_bursts++;
        repeat (2) begin
          @(negedge clk);
          if (!mem_wr_req || int'(mem_wr_addr) != wa || int'(mem_wr_len) != wl) hold_err++;
        end
        mem_wr_ack = 1; @(negedge clk); mem_wr_ack = 0;
        wk = 0; prev_stall = 0;
        while (wk < wl) begin
          if (prev_stall && mem_wr_data !== prev_data) hold_err++;
          mem_wr_ready = (wgap % 5) != 2; wgap++;
          if (mem_wr_valid && mem_wr_ready) begin
            mem[(wa + wk) % MEMSZ] = mem_wr_data;
            wk++; prev_stall = 0;
          end else begin
            prev_stall = mem_wr_valid; prev_data = mem_wr_data;
          end
          @(negedge clk);
        end
        mem_wr_ready = 0;
      end
    end
  end

  function automatic logic [3:0] tbl_fn(input int kind, input int a, input int b);
    case (kind)
      0: return 4'(a);
      1: return 4'(b);
      2: return 4'h0;
      3: return 4'((a + b) / 2);
      default: return (a < 8) ? 4'h1 : ((b < 8) ? 4'h6 : 4'hC);
    endcase
  endfunction

  task automatic load_tbl(input int kind);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      tbl_we = 1; tbl_addr = 8'(i); tbl_data = tbl_fn(kind, i / 16, i % 16);
      ref_tbl[i] = tbl_data;
    end
    @(negedge clk); tbl_we = 0;
  endtask

  function automatic logic [11:0] model(input logic [11:0] a, input logic [11:0] b);
    logic [11:0] y;
    for (int c = 0; c < 3; c++) y[c*4 +: 4] = ref_tbl[{a[c*4 +: 4], b[c*4 +: 4]}];
    return y;
  endfunction

  task automatic fill_images();
    for (int i = 0; i < 256; i++) begin
      logic [3:0] hi, lo;
      hi = 4'(i / 16); lo = 4'(i % 16);
      mem[i]       = {hi, hi ^ 4'h3, ~hi};
      mem[256 + i] = {lo, lo + 4'h5, lo ^ 4'h9};
    end
    for (int i = 512; i < MEMSZ; i++) mem[i] = 12'h5A5;
  endtask

  // runs a job; disturb=1 issues table writes and a stray start mid-job (R6, R9)
  task automatic run(input string tag, input int a, input int b, input int d, input int n,
                     input logic disturb);
    int errs, first_act, first_exp, waited;
    logic [11:0] exp_img [256];
    for (int i = 0; i < n; i++) exp_img[i] = model(mem[(a + i) % MEMSZ], mem[(b + i) % MEMSZ]);
    cur_a = a; cur_b = b; cur_d = d; cur_n = n;
    rd_bursts = 0; wr_bursts = 0; rd_err = 0; wr_err = 0; hold_err = 0;
    @(negedge clk);
    cfg_src_a = 16'(a); cfg_src_b = 16'(b); cfg_dst = 16'(d); cfg_count = 16'(n);
    start = 1;
    @(negedge clk); start = 0;
    if (n == 0) begin
      check({tag, " R8 done next cycle"}, done && !busy, int'(done), 1);
    end else begin
      check({tag, " R6 busy after start"}, busy, int'(busy), 1);
      if (disturb) begin
        for (int i = 0; i < 256; i++) begin
          tbl_we = 1; tbl_addr = 8'(i); tbl_data = 4'hF;
          @(negedge clk);
        end
        tbl_we = 0;
        cfg_src_a = 16'd700; cfg_dst = 16'd900; cfg_count = 16'd3; start = 1;
        @(negedge clk); start = 0;
      end
      waited = 0;
      while (!done && waited < 20000) begin @(negedge clk); waited++; end
      check({tag, " R7 done with busy low"}, done && !busy, int'(busy), 0);
    end
    @(negedge clk);
    check({tag, " R7 done lasts one cycle"}, !done, int'(done), 0);
    repeat (8) @(negedge clk);
    check({tag, " R6 no second job"}, !busy && !mem_rd_req && !done, int'(busy), 0);
    errs = 0; first_act = 0; first_exp = 0;
    for (int i = 0; i < n; i++) begin
      if (mem[(d + i) % MEMSZ] !== exp_img[i]) begin
        if (errs == 0) begin first_act = int'(mem[(d + i) % MEMSZ]); first_exp = int'(exp_img[i]); end
        errs++;
      end
    end
    check({tag, " R1 pixel results"}, errs == 0, first_act, first_exp);
    if (n < 400 && d + n < MEMSZ)
      check({tag, " R3 no write past end"}, mem[d + n] === 12'h5A5, int'(mem[d + n]), 'h5A5);
    check({tag, " R2 read burst count"}, rd_bursts == 2 * ((n + BURST - 1) / BURST), rd_bursts,
          2 * ((n + BURST - 1) / BURST));
    check({tag, " R2 write burst count"}, wr_bursts == (n + BURST - 1) / BURST, wr_bursts,
          (n + BURST - 1) / BURST);
    check({tag, " R2 R3 request addr/len"}, rd_err == 0 && wr_err == 0, rd_err + wr_err, 0);
    check({tag, " R4 R5 hold under stall"}, hold_err == 0, hold_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; tbl_we = 0; tbl_addr = '0; tbl_data = '0;
    cfg_src_a = '0; cfg_src_b = '0; cfg_dst = '0; cfg_count = '0;
    cur_a = 0; cur_b = 0; cur_d = 0; cur_n = 0;
    rd_bursts = 0; wr_bursts = 0; rd_err = 0; wr_err = 0; hold_err = 0;
    repeat (3) @(negedge clk);
    check("R10 reset outputs",
          !busy && !done && !mem_rd_req && !mem_wr_req && !mem_rd_ready && !mem_wr_valid,
          int'({busy, done, mem_rd_req, mem_wr_req, mem_rd_ready, mem_wr_valid}), 0);
    rst_n = 1;
    @(negedge clk);

    fill_images(); load_tbl(0); run("copyA", 0, 256, 512, 256, 1'b0);
    fill_images(); load_tbl(1); run("copyB", 0, 256, 512, 256, 1'b0);
    fill_images(); load_tbl(2); run("clear", 0, 256, 512, 256, 1'b0);
    fill_images(); load_tbl(3); run("blend", 0, 256, 512, 256, 1'b0);
    fill_images(); load_tbl(4); run("thresh", 0, 256, 512, 256, 1'b0);
    fill_images(); load_tbl(3); run("partial", 20, 300, 600, 150, 1'b0);
    fill_images(); run("R9 busy writes", 0, 256, 512, 256, 1'b1);
    fill_images(); run("R9 after", 5, 261, 700, 64, 1'b0);
    run("R8 zero", 0, 256, 512, 0, 1'b0);
    check("R8 no request for zero", rd_bursts == 0 && wr_bursts == 0, rd_bursts + wr_bursts, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule